// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block produces one asynchronous NAND flash bus cycle at a time: a command byte, an address byte, a data read or a data write. Every cycle is split into four phases whose lengths come from a programmed timing word and are counted in controller clocks. The phases are setup, strobe, hold and bus release. A read that comes directly after a command or an address cycle is held back by a separate programmed gap, so that the latch-enable line has settled before the read strobe falls.

The host programs three words through a small configuration port: a control word, a common timing word and an attribute timing word. It then issues accesses with a start strobe. An access is accepted only while `req_ready` is high. When the access ends, `done` pulses for one clock and `rd_data` holds the last word read.

The state machine has six states:
- IDLE moves to GAP, SETUP or STROBE on an accepted start, taking the first of them whose length is non-zero.
- GAP moves to SETUP, or to STROBE if the setup length is zero.
- SETUP moves to STROBE.
- STROBE moves to HOLD.
- HOLD moves to RELEASE for cycles that drive the bus and have a non-zero release length. Otherwise it moves to IDLE.
- RELEASE moves to IDLE.

Each state leaves when its down-counter reaches zero. Entering IDLE from HOLD or RELEASE raises `done` for the next clock.

Top module: `nand_cycle_seq`

## Requirements
- R1: `nand_ce_n` is low exactly while control bit 2 (enable) is 1. While that bit is 0, `req_ready` stays low, starts are ignored and the bus stays idle. The reset value of the bit is 0.
- R2: An accepted access appears on the bus from the next clock in this order:
  - setup, with both strobes high;
  - strobe, with `nand_we_n` low for command, address and write, or `nand_re_n` low for read;
  - hold, identical to setup;
  - release, only for command, address and write, with all lines idle and `nand_dq_oe` low.
  
  Then `done` is high for exactly one clock, in which the block is idle.
- R3: The phase lengths in clocks come from the timing word: setup in bits 7:0, strobe in bits 15:8, hold in bits 23:16 and release in bits 31:24. A setup or release length of 0 skips that phase. A strobe or hold length of 0 acts as 1. The reset value of both timing words is setup 0, strobe 6, hold 4, release 1 (32'h0104_0600).
- R4: An access with `req_attr` = 1 uses the attribute timing word. An access with `req_attr` = 0 uses the common timing word.
- R5: A read that directly follows a command access is preceded by a gap of idle clocks. Its length is the command-to-read delay in control bits 12:9. A read that directly follows an address access is preceded by the address-to-read delay in control bits 16:13. Both delays reset to 1. Every other access has no gap.
- R6: The timing, kind, width and write data are captured when the access is accepted. Configuration writes made during an access do not change that access.
- R7: While control bit 1 (wait on ready) is 1 and `nand_rb` is low, `req_ready` is low and no access starts. A held start is accepted at the first clock edge after `nand_rb` goes high.
- R8: Read data is sampled from `nand_dq_in` on the last strobe clock of a read. In 8-bit mode the upper byte of the sample reads as zero. `rd_data` holds the value until the next read samples.
- R9: Control bit 4 selects a 16-bit device. In 16-bit mode `nand_dq_out` carries the full write word. In 8-bit mode its upper byte is zero. The data bus is driven (`nand_dq_oe` high) in setup, strobe and hold of non-read accesses only.
- R10: Access kind codes are 0 command (`nand_cle` high in setup, strobe and hold), 1 address (`nand_ale` high in the same phases), 2 read and 3 write. Configuration address 0 is the control word, 1 the common timing word and 2 the attribute timing word. Writes to address 3 are ignored.
- R11: `req_ready` is high only in the idle state, which includes the `done` clock. A start is accepted on a rising edge at which both `req_start` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| req_start | input | 1 | Access start request |
| req_kind | input | 2 | Access kind code |
| req_attr | input | 1 | Use attribute timing word |
| req_wdata | input | 16 | Word for command, address or write |
| req_ready | output | 1 | Block can accept a start |
| done | output | 1 | One-clock pulse at the end of an access |
| rd_data | output | 16 | Last word read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus, outgoing |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus, incoming |
| nand_rb | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The hardest situations to reach are the interactions between consecutive accesses. These are the read gap, which depends on the kind of the previous access, and a start placed in the very `done` clock of the access before it. The bench chains command, address, read and write accesses with no idle clocks between them, then issues the next start on the `done` clock. It also rewrites timing and control words while a long strobe phase is running, to show that the access in flight keeps its captured values. A start held against a low ready/busy line, and timing words with zero and 255 field values, cover the skipped-phase, floored-phase and longest-phase boundaries.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

    localparam int CNT_W     = 8;
    localparam int DLY_W     = 4;
    localparam int CFG_A_W   = 2;

    // control word bit positions
    localparam int CTL_WAITRDY = 1;
    localparam int CTL_ENABLE  = 2;
    localparam int CTL_WIDE    = 4;
    localparam int CTL_CLE_LSB = 9;
    localparam int CTL_ALE_LSB = 13;

    localparam logic [31:0] TIM_RESET = 32'h0104_0600;

    typedef struct packed {
        logic [CNT_W-1:0] release_n;
        logic [CNT_W-1:0] hold_n;
        logic [CNT_W-1:0] wait_n;
        logic [CNT_W-1:0] setup_n;
    } timing_t;

    typedef struct packed {
        logic [DLY_W-1:0] ale_dly;
        logic [DLY_W-1:0] cle_dly;
        logic             wide;
        logic             enable;
        logic             wait_rdy;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ale_dly: DLY_W'(1), cle_dly: DLY_W'(1),
                                     wide: 1'b0, enable: 1'b0, wait_rdy: 1'b0};

    typedef enum logic [1:0] {
        ACC_CMD   = 2'd0,
        ACC_ADDR  = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_GAP     = 3'd1,
        PH_SETUP   = 3'd2,
        PH_STROBE  = 3'd3,
        PH_HOLD    = 3'd4,
        PH_RELEASE = 3'd5
    } phase_e;

    // strobe and hold lengths never go below one clock
    function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/nand_cfg_regs.sv
`timescale 1ns/1ps
module nand_cfg_regs
    import nand_seq_pkg::*;
#(
    parameter int N_TIM = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_A_W-1:0]   cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output ctrl_t                ctrl_q,
    output logic [N_TIM*32-1:0]  tim_flat
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (cfg_we && cfg_addr == '0) begin
            ctrl_q.wait_rdy <= cfg_wdata[CTL_WAITRDY];
            ctrl_q.enable   <= cfg_wdata[CTL_ENABLE];
            ctrl_q.wide     <= cfg_wdata[CTL_WIDE];
            ctrl_q.cle_dly  <= cfg_wdata[CTL_CLE_LSB +: DLY_W];
            ctrl_q.ale_dly  <= cfg_wdata[CTL_ALE_LSB +: DLY_W];
        end
    end

    for (genvar g = 0; g < N_TIM; g++) begin : g_tim
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= TIM_RESET;
            end else if (cfg_we && cfg_addr == CFG_A_W'(g + 1)) begin
                word_q <= cfg_wdata;
            end
        end
        assign tim_flat[g*32 +: 32] = word_q;
    end

endmodule

// File: rtl/nand_phase_ctrl.sv
`timescale 1ns/1ps
module nand_phase_ctrl
    import nand_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  acc_kind_e        kind_in,
    input  timing_t          tim_in,
    input  logic [DLY_W-1:0] cle_dly,
    input  logic [DLY_W-1:0] ale_dly,
    output phase_e           phase,
    output acc_kind_e        kind_q,
    output logic             idle,
    output logic             last_strobe,
    output logic             done
);

    phase_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    timing_t          tim_q, tim_d;
    acc_kind_e        kind_d;
    acc_kind_e        prev_q;
    logic             prev_vld_q;
    logic             done_q, done_d;
    logic [DLY_W-1:0] gap_len;

    // gap ahead of a read depends on the kind of the access before it
    always_comb begin
        gap_len = '0;
        if (kind_in == ACC_READ && prev_vld_q) begin
            if (prev_q == ACC_CMD) begin
                gap_len = cle_dly;
            end else if (prev_q == ACC_ADDR) begin
                gap_len = ale_dly;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= PH_IDLE;
            cnt_q      <= '0;
            tim_q      <= TIM_RESET;
            kind_q     <= ACC_CMD;
            prev_q     <= ACC_CMD;
            prev_vld_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            tim_q  <= tim_d;
            kind_q <= kind_d;
            done_q <= done_d;
            if (start) begin
                prev_q     <= kind_in;
                prev_vld_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        tim_d  = tim_q;
        kind_d = kind_q;
        done_d = 1'b0;
        unique case (st_q)
            PH_IDLE: begin
                if (start) begin
                    tim_d  = tim_in;
                    kind_d = kind_in;
                    if (gap_len != '0) begin
                        st_d  = PH_GAP;
                        cnt_d = CNT_W'(gap_len) - CNT_W'(1);
                    end else if (tim_in.setup_n != '0) begin
                        st_d  = PH_SETUP;
                        cnt_d = tim_in.setup_n - CNT_W'(1);
                    end else begin
                        st_d  = PH_STROBE;
                        cnt_d = floor_one(tim_in.wait_n) - CNT_W'(1);
                    end
                end
            end
            PH_GAP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (tim_q.setup_n != '0) begin
                    st_d  = PH_SETUP;
                    cnt_d = tim_q.setup_n - CNT_W'(1);
                end else begin
                    st_d  = PH_STROBE;
                    cnt_d = floor_one(tim_q.wait_n) - CNT_W'(1);
                end
            end
            PH_SETUP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else begin
                    st_d  = PH_STROBE;
                    cnt_d = floor_one(tim_q.wait_n) - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else begin
                    st_d  = PH_HOLD;
                    cnt_d = floor_one(tim_q.hold_n) - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (kind_q != ACC_READ && tim_q.release_n != '0) begin
                    st_d  = PH_RELEASE;
                    cnt_d = tim_q.release_n - CNT_W'(1);
                end else begin
                    st_d   = PH_IDLE;
                    done_d = 1'b1;
                end
            end
            PH_RELEASE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else begin
                    st_d   = PH_IDLE;
                    done_d = 1'b1;
                end
            end
            default: begin
                st_d = PH_IDLE;
            end
        endcase
    end

    assign phase       = st_q;
    assign idle        = (st_q == PH_IDLE);
    assign last_strobe = (st_q == PH_STROBE) && (cnt_q == '0);
    assign done        = done_q;

endmodule

// File: rtl/nand_bus_drv.sv
`timescale 1ns/1ps
module nand_bus_drv
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  phase_e            phase,
    input  acc_kind_e         kind_q,
    input  logic              last_strobe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HALF = DATA_W / 2;

    logic              wide_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_q;
    logic              is_read;
    logic              is_cmd;
    logic              is_addr;

    function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] v, input logic w);
        return w ? v : {{(DATA_W-HALF){1'b0}}, v[HALF-1:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            if (start) begin
                wide_q  <= wide_in;
                wdata_q <= narrow(wdata_in, wide_in);
            end
            if (last_strobe && kind_q == ACC_READ) begin
                rd_q <= narrow(dq_in, wide_q);
            end
        end
    end

    assign is_read = (kind_q == ACC_READ);
    assign is_cmd  = (kind_q == ACC_CMD);
    assign is_addr = (kind_q == ACC_ADDR);

    // bus outputs decoded from the phase
    always_comb begin
        cle   = 1'b0;
        ale   = 1'b0;
        we_n  = 1'b1;
        re_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (phase)
            PH_SETUP, PH_HOLD: begin
                cle   = is_cmd;
                ale   = is_addr;
                dq_oe = !is_read;
            end
            PH_STROBE: begin
                cle   = is_cmd;
                ale   = is_addr;
                dq_oe = !is_read;
                we_n  = is_read;
                re_n  = !is_read;
            end
            default: begin
            end
        endcase
    end

    assign dq_out  = wdata_q;
    assign rd_data = rd_q;

endmodule

// File: rtl/nand_cycle_seq.sv
`timescale 1ns/1ps
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_start,
    input  logic [1:0]        req_kind,
    input  logic              req_attr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb
);

    localparam int N_TIM = 2;

    ctrl_t              ctrl_q;
    logic [N_TIM*32-1:0] tim_flat;
    timing_t            tim_sel;
    phase_e             phase;
    acc_kind_e          kind_q;
    logic               idle;
    logic               last_strobe;
    logic               start;

    nand_cfg_regs #(.N_TIM(N_TIM)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl_q    (ctrl_q),
        .tim_flat  (tim_flat)
    );

    assign tim_sel   = timing_t'(req_attr ? tim_flat[32 +: 32] : tim_flat[0 +: 32]);
    assign req_ready = idle && ctrl_q.enable && (!ctrl_q.wait_rdy || nand_rb);
    assign start     = req_start && req_ready;
    assign nand_ce_n = !ctrl_q.enable;

    nand_phase_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .kind_in     (acc_kind_e'(req_kind)),
        .tim_in      (tim_sel),
        .cle_dly     (ctrl_q.cle_dly),
        .ale_dly     (ctrl_q.ale_dly),
        .phase       (phase),
        .kind_q      (kind_q),
        .idle        (idle),
        .last_strobe (last_strobe),
        .done        (done)
    );

    nand_bus_drv #(.DATA_W(DATA_W)) u_drv (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wide_in     (ctrl_q.wide),
        .wdata_in    (req_wdata),
        .phase       (phase),
        .kind_q      (kind_q),
        .last_strobe (last_strobe),
        .dq_in       (nand_dq_in),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .dq_oe       (nand_dq_oe),
        .dq_out      (nand_dq_out),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/nand_cycle_seq_chk.sv
`timescale 1ns/1ps
module nand_cycle_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_start,
    input logic              req_ready,
    input logic              done,
    input logic              nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              nand_dq_oe,
    input logic [DATA_W-1:0] nand_dq_out,
    input logic              nand_rb,
    input logic              wait_rdy
);

    p_strobe_needs_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!nand_we_n, !nand_re_n}));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

    p_stall_on_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_rdy && !nand_rb) |-> !req_ready);

    p_read_bus_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    p_latch_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && req_ready) |=> !req_ready);

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .req_ready   (req_ready),
    .done        (done),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_oe  (nand_dq_oe),
    .nand_dq_out (nand_dq_out),
    .nand_rb     (nand_rb),
    .wait_rdy    (ctrl_q.wait_rdy)
);

// File: tb/nand_cycle_seq_tb.sv
`timescale 1ns/1ps
module nand_cycle_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_start = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_attr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;
    logic        nand_rb = 1'b1;

    always #2.5 clk = ~clk;

    nand_cycle_seq #(.DATA_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_start(req_start), .req_kind(req_kind),
        .req_attr(req_attr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    typedef struct packed {
        logic        cle;
        logic        ale;
        logic        we_n;
        logic        re_n;
        logic        oe;
        logic        dn;
        logic        rdchk;
        logic [15:0] dq;
        logic [15:0] rd;
    } exp_t;

    exp_t        exp_q[$];
    int          vectors = 0;
    int          fails = 0;
    logic [31:0] m_ctrl = 32'h0000_2200;
    logic [31:0] m_tim [2] = '{32'h0104_0600, 32'h0104_0600};
    int          m_prev = -1;
    logic [15:0] m_rd = '0;
    bit          acc_last = 1'b0;
    bit          done_last = 1'b0;

    function automatic void check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
        end
    endfunction

    function automatic void put(int n, logic c, logic a, logic w, logic r, logic o, logic [15:0] d);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{cle: c, ale: a, we_n: w, re_n: r, oe: o, dn: 1'b0,
                              rdchk: 1'b0, dq: d, rd: 16'h0});
        end
    endfunction

    // behavioural expectation of one access, one entry per clock
    function automatic void model_access(int kind, bit attr, logic [15:0] wd, logic [15:0] din);
        logic [31:0] t;
        bit          wide, rd;
        int          gap, s, w, h, z;
        logic [15:0] d;
        t    = m_tim[attr];
        wide = m_ctrl[4];
        rd   = (kind == 2);
        gap  = 0;
        if (rd && m_prev == 0) gap = int'(m_ctrl[12:9]);
        if (rd && m_prev == 1) gap = int'(m_ctrl[16:13]);
        s = int'(t[7:0]);
        w = (t[15:8] == 0) ? 1 : int'(t[15:8]);
        h = (t[23:16] == 0) ? 1 : int'(t[23:16]);
        z = rd ? 0 : int'(t[31:24]);
        d = wide ? wd : {8'h00, wd[7:0]};
        put(gap, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, d);
        put(s, kind == 0, kind == 1, 1'b1, 1'b1, !rd, d);
        put(w, kind == 0, kind == 1, rd, !rd, !rd, d);
        put(h, kind == 0, kind == 1, 1'b1, 1'b1, !rd, d);
        put(z, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, d);
        exp_q.push_back('{cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1, oe: 1'b0, dn: 1'b1,
                          rdchk: rd, dq: d, rd: (wide ? din : {8'h00, din[7:0]})});
        m_prev = kind;
    endfunction

    task automatic tick();
        exp_t e;
        bit   rdy;
        #1;
        rdy = (exp_q.size() == 0) && m_ctrl[2] && (!m_ctrl[1] || nand_rb) && rst_n;
        check(req_ready === rdy, "R11", "req_ready", 32'(req_ready), 32'(rdy));
        acc_last = req_start && rdy;
        if (acc_last) model_access(int'(req_kind), req_attr, req_wdata, nand_dq_in);
        if (cfg_we && rst_n) begin
            case (cfg_addr)
                2'd0: m_ctrl = cfg_wdata & 32'h0001_FE16;
                2'd1: m_tim[0] = cfg_wdata;
                2'd2: m_tim[1] = cfg_wdata;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else e = '{cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1, oe: 1'b0, dn: 1'b0,
                   rdchk: 1'b0, dq: 16'h0, rd: 16'h0};
        done_last = e.dn;
        check(nand_ce_n === !m_ctrl[2], "R1", "nand_ce_n", 32'(nand_ce_n), 32'(!m_ctrl[2]));
        check({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe} ===
              {e.cle, e.ale, e.we_n, e.re_n, e.oe}, "R2", "bus lines {cle,ale,we,re,oe}",
              32'({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}),
              32'({e.cle, e.ale, e.we_n, e.re_n, e.oe}));
        check(done === e.dn, "R2", "done", 32'(done), 32'(e.dn));
        if (e.oe) check(nand_dq_out === e.dq, "R9", "nand_dq_out", 32'(nand_dq_out), 32'(e.dq));
        if (e.dn) begin
            if (e.rdchk) m_rd = e.rd;
            check(rd_data === m_rd, "R8", "rd_data", 32'(rd_data), 32'(m_rd));
        end
    endtask

    task automatic cfg(logic [1:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic issue(int k, bit attr, logic [15:0] wd);
        req_kind = 2'(k); req_attr = attr; req_wdata = wd; req_start = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            tick();
            if (acc_last) break;
        end
        req_start = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() > 0; i++) tick();
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset state, chip disabled and bus idle
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: start while enable is clear is ignored
        req_kind = 2'd3; req_wdata = 16'h1234; req_start = 1'b1;
        repeat (4) tick();
        req_start = 1'b0;
        tick();

        // enable, 8-bit, reset delays
        cfg(2'd0, 32'h0000_2204);
        // R10 R2 R3: command then address with reset timing
        issue(0, 1'b0, 16'h0070); drain();
        issue(1, 1'b0, 16'h0012); drain();
        // R5: read after address gets the address gap; R8 8-bit sample
        nand_dq_in = 16'hBEEF;
        issue(2, 1'b0, 16'h0); drain();
        // R5: read after read has no gap
        nand_dq_in = 16'h5A3C;
        issue(2, 1'b0, 16'h0); drain();
        // R5: command delay 3 in front of a read
        cfg(2'd0, 32'h0000_2604);
        issue(0, 1'b0, 16'h0090); drain();
        nand_dq_in = 16'h0F0F;
        issue(2, 1'b0, 16'h0); drain();
        // R9: write in 8-bit mode then 16-bit mode
        issue(3, 1'b0, 16'hA5C3); drain();
        cfg(2'd0, 32'h0000_2614);
        issue(3, 1'b0, 16'hA5C3); drain();
        // R8: 16-bit read; a later write leaves rd_data alone
        nand_dq_in = 16'hC0DE;
        issue(2, 1'b0, 16'h0); drain();
        issue(3, 1'b0, 16'h1111); drain();
        // R3: all-zero timing, strobe and hold floor at one clock
        cfg(2'd1, 32'h0000_0000);
        issue(3, 1'b0, 16'h2222); drain();
        issue(2, 1'b0, 16'h0); drain();
        cfg(2'd1, 32'h0302_0502);
        issue(0, 1'b0, 16'h00FF); drain();
        // R4: attribute timing word versus common word
        cfg(2'd2, 32'h0201_0304);
        issue(3, 1'b1, 16'h3333); drain();
        issue(3, 1'b0, 16'h4444); drain();
        // R3: longest strobe
        cfg(2'd1, 32'h0001_FF01);
        nand_dq_in = 16'h7E81;
        issue(2, 1'b0, 16'h0); drain();
        // R6: configuration changes during a long write
        cfg(2'd1, 32'h0102_1401);
        issue(3, 1'b0, 16'h9876);
        cfg(2'd1, 32'h0000_0000);
        cfg(2'd0, 32'h0000_2604);
        drain();
        // R10: address 3 is ignored, timing stays all zero
        cfg(2'd3, 32'hFFFF_FFFF);
        issue(3, 1'b0, 16'h5555); drain();
        // R11: back-to-back starts, the next in the done clock
        issue(0, 1'b0, 16'h0030); drain();
        issue(1, 1'b0, 16'h0044); drain();
        nand_dq_in = 16'h00AB;
        issue(2, 1'b0, 16'h0); drain();
        // R7: wait on ready stalls a held start until ready
        cfg(2'd0, 32'h0000_2606);
        nand_rb = 1'b0;
        req_kind = 2'd3; req_attr = 1'b0; req_wdata = 16'h6060; req_start = 1'b1;
        repeat (5) tick();
        nand_rb = 1'b1;
        tick();
        req_start = 1'b0;
        drain();
        // R1: clearing enable raises chip enable
        cfg(2'd0, 32'h0000_2600);
        repeat (3) tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule